// File: doc/BRIEF.md
# Static-Dynamic Hybrid Branch Direction Predictor

This block guesses the direction of conditional branches for a small embedded core. Each branch arrives with two hint bits produced by offline profiling. One hint bit sends the branch either to a fixed direction rule or to a very small table of saturating counters, indexed in GShare fashion by PC bits XORed with global history. The other hint bit sets the polarity of the fixed rule. Branches marked static never touch the table, which lowers table traffic and the aliasing between branches that share an entry.

The prediction is combinational from the fetch inputs. The table index used for a dynamic prediction is driven out as `pred_index`. The core carries that index down the pipeline and returns it on the resolve port with the actual outcome. A free-running counter records every table read, so the number of reads avoided by static hints can be measured.

Top module: `hybrid_bpred`

## Requirements
- R1: Reset is synchronous and active-high. It sets every table counter to 01 (weakly not taken), clears the 4-bit global history to zero and clears `access_count` to zero.
- R2: When `fetch_hint[1]`=0 (static) and `fetch_hint[0]`=0, `pred_taken` equals `fetch_backward`. A backward target (lower address) is predicted taken and a forward target is predicted not taken.
- R3: When `fetch_hint[1]`=0 and `fetch_hint[0]`=1, `pred_taken` equals the inverse of `fetch_backward`. A backward target is predicted not taken and a forward target is predicted taken.
- R4: A static fetch (`fetch_valid`=1, `fetch_hint[1]`=0) does not read the table and leaves `access_count` unchanged.
- R5: A resolve with `res_dynamic`=0 leaves every table counter unchanged, whatever the value of `res_taken`.
- R6: `pred_index` equals `fetch_pc[5:2]` XOR history[3:0].
- R7: When `fetch_valid`=1 and `fetch_hint[1]`=1, `pred_taken` is bit 1 of the counter at `pred_index`.
- R8: A resolve with `res_dynamic`=1 changes the counter at `res_index`. It adds one when `res_taken`=1 and subtracts one when `res_taken`=0. The counter holds at 3 and at 0.
- R9: Every resolve (`res_valid`=1), static or dynamic, shifts `res_taken` into history bit 0, and the older bits move up by one place.
- R10: `access_count` increases by exactly one after each clock edge at which a dynamic fetch is presented. It wraps modulo 2^32.
- R11: While `fetch_valid`=0, `pred_taken` is 0 and `access_count` does not change.
- R12: When a fetch and a resolve arrive in the same cycle, the prediction uses the table and history as they stood before that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fetch_valid | input | 1 | A conditional branch is being fetched |
| fetch_pc | input | 32 | Address of the branch |
| fetch_backward | input | 1 | 1 when the target lies below the branch address |
| fetch_hint | input | 2 | Bit 1: use table; bit 0: static polarity (0 backward-taken, 1 forward-taken) |
| res_valid | input | 1 | A conditional branch has resolved |
| res_taken | input | 1 | Actual outcome of the resolved branch |
| res_dynamic | input | 1 | The resolved branch was predicted from the table |
| res_index | input | 4 | Table index returned from prediction time |
| pred_taken | output | 1 | Predicted direction |
| pred_index | output | 4 | Table index for this fetch |
| access_count | output | 32 | Number of table reads since reset |

## Verification
The assertions assume that `res_index` is an index the block produced earlier. They also assume the inputs are stable and known at each rising edge. No assertion constrains how fetches and resolves are ordered, so the checks are valid for any interleaving. The stimulus drives every input on the falling edge. Resolves of dynamic branches pop indices from a queue filled with earlier `pred_index` values, and only fall back to a random index when that queue is empty. This matches how a core would return the index. Directed passes push a single entry into both saturation limits. They also send resolves of static branches that must leave the table alone, and they place fetch and resolve in the same cycle.

// File: rtl/bpred_pkg.sv
package bpred_pkg;

    // hint bit 1 selects the source, hint bit 0 the static polarity
    typedef enum logic {
        SRC_STATIC  = 1'b0,
        SRC_DYNAMIC = 1'b1
    } src_e;

    typedef enum logic {
        POL_BACK_TAKEN = 1'b0,
        POL_FWD_TAKEN  = 1'b1
    } pol_e;

    typedef struct packed {
        src_e source;
        pol_e polarity;
    } hint_t;

endpackage

// File: rtl/static_dir.sv
module static_dir
    import bpred_pkg::*;
(
    input  logic backward,
    input  pol_e polarity,
    output logic taken
);
    always_comb begin
        unique case (polarity)
            POL_BACK_TAKEN: taken = backward;
            POL_FWD_TAKEN:  taken = ~backward;
            default:        taken = 1'b0;
        endcase
    end
endmodule

// File: rtl/ghist_reg.sv
module ghist_reg #(
    parameter int HIST_W = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              shift_en,
    input  logic              shift_bit,
    output logic [HIST_W-1:0] hist
);
    typedef struct packed {
        logic [HIST_W-1:0] bits;
    } hist_state_t;

    hist_state_t state_d, state_q;

    always_comb begin
        state_d = state_q;
        if (shift_en) begin
            state_d.bits = {state_q.bits[HIST_W-2:0], shift_bit};
        end
        if (rst) begin
            state_d.bits = '0;
        end
    end

    always_ff @(posedge clk) begin
        state_q <= state_d;
    end

    assign hist = state_q.bits;

    // R9
    hist_shift_chk: assert property (@(posedge clk) disable iff (rst)
        shift_en |=> (hist[0] == $past(shift_bit))
                  && (hist[HIST_W-1:1] == $past(hist[HIST_W-2:0])));

    // R9
    hist_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !shift_en |=> $stable(hist));
endmodule

// File: rtl/pattern_table.sv
module pattern_table #(
    parameter int IDX_W = 4,
    parameter int CNT_W = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [IDX_W-1:0] rd_idx,
    output logic [CNT_W-1:0] rd_ctr,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic             wr_taken
);
    localparam int ENTRIES = 1 << IDX_W;
    localparam logic [CNT_W-1:0] CTR_MAX = {CNT_W{1'b1}};
    localparam logic [CNT_W-1:0] CTR_MIN = '0;
    localparam logic [CNT_W-1:0] WEAK_NT = CTR_MAX >> 1;

    typedef struct packed {
        logic [ENTRIES-1:0][CNT_W-1:0] ctr;
    } tbl_state_t;

    tbl_state_t state_d, state_q;

    always_comb begin
        state_d = state_q;
        if (wr_en) begin
            if (wr_taken) begin
                if (state_q.ctr[wr_idx] != CTR_MAX) begin
                    state_d.ctr[wr_idx] = state_q.ctr[wr_idx] + CNT_W'(1);
                end
            end else begin
                if (state_q.ctr[wr_idx] != CTR_MIN) begin
                    state_d.ctr[wr_idx] = state_q.ctr[wr_idx] - CNT_W'(1);
                end
            end
        end
        if (rst) begin
            for (int e = 0; e < ENTRIES; e++) begin
                state_d.ctr[e] = WEAK_NT;
            end
        end
    end

    always_ff @(posedge clk) begin
        state_q <= state_d;
    end

    assign rd_ctr = state_q.ctr[rd_idx];

    // R8
    ctr_top_sat_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_taken && state_q.ctr[wr_idx] == CTR_MAX)
        |=> state_q.ctr[$past(wr_idx)] == CTR_MAX);

    // R8
    ctr_bot_sat_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !wr_taken && state_q.ctr[wr_idx] == CTR_MIN)
        |=> state_q.ctr[$past(wr_idx)] == CTR_MIN);

    // R8
    ctr_step_up_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_taken && state_q.ctr[wr_idx] != CTR_MAX)
        |=> state_q.ctr[$past(wr_idx)] == $past(state_q.ctr[wr_idx]) + CNT_W'(1));

    // R5
    tbl_untouched_chk: assert property (@(posedge clk) disable iff (rst)
        !wr_en |=> $stable(state_q));
endmodule

// File: rtl/access_ctr.sv
module access_ctr #(
    parameter int ACC_W = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             inc,
    output logic [ACC_W-1:0] count
);
    typedef struct packed {
        logic [ACC_W-1:0] value;
    } acc_state_t;

    acc_state_t state_d, state_q;

    always_comb begin
        state_d = state_q;
        if (inc) begin
            state_d.value = state_q.value + ACC_W'(1);
        end
        if (rst) begin
            state_d.value = '0;
        end
    end

    always_ff @(posedge clk) begin
        state_q <= state_d;
    end

    assign count = state_q.value;

    // R10
    acc_step_chk: assert property (@(posedge clk) disable iff (rst)
        inc |=> count == $past(count) + ACC_W'(1));

    // R10
    acc_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !inc |=> $stable(count));
endmodule

// File: rtl/hybrid_bpred.sv
module hybrid_bpred
    import bpred_pkg::*;
#(
    parameter int PC_W   = 32,
    parameter int PC_LSB = 2,
    parameter int IDX_W  = 4,
    parameter int CNT_W  = 2,
    parameter int ACC_W  = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             fetch_valid,
    input  logic [PC_W-1:0]  fetch_pc,
    input  logic             fetch_backward,
    input  logic [1:0]       fetch_hint,
    input  logic             res_valid,
    input  logic             res_taken,
    input  logic             res_dynamic,
    input  logic [IDX_W-1:0] res_index,
    output logic             pred_taken,
    output logic [IDX_W-1:0] pred_index,
    output logic [ACC_W-1:0] access_count
);
    localparam int HIST_W = IDX_W;
    localparam int PC_HI  = PC_LSB + IDX_W;

    hint_t             hint;
    logic [HIST_W-1:0] hist;
    logic [CNT_W-1:0]  ctr;
    logic              static_taken;
    logic              dyn_read;
    logic              dyn_write;
    logic              unused_pc_bits;

    assign hint           = hint_t'(fetch_hint);
    assign unused_pc_bits = ^{fetch_pc[PC_W-1:PC_HI], fetch_pc[PC_LSB-1:0]};
    assign pred_index     = fetch_pc[PC_HI-1:PC_LSB] ^ hist;
    assign dyn_read       = fetch_valid && (hint.source == SRC_DYNAMIC);
    assign dyn_write      = res_valid && res_dynamic;

    static_dir i_static (
        .backward (fetch_backward),
        .polarity (hint.polarity),
        .taken    (static_taken)
    );

    ghist_reg #(.HIST_W(HIST_W)) i_hist (
        .clk       (clk),
        .rst       (rst),
        .shift_en  (res_valid),
        .shift_bit (res_taken),
        .hist      (hist)
    );

    pattern_table #(.IDX_W(IDX_W), .CNT_W(CNT_W)) i_table (
        .clk      (clk),
        .rst      (rst),
        .rd_idx   (pred_index),
        .rd_ctr   (ctr),
        .wr_en    (dyn_write),
        .wr_idx   (res_index),
        .wr_taken (res_taken)
    );

    access_ctr #(.ACC_W(ACC_W)) i_acc (
        .clk   (clk),
        .rst   (rst),
        .inc   (dyn_read),
        .count (access_count)
    );

    always_comb begin
        if (!fetch_valid) begin
            pred_taken = 1'b0;
        end else if (hint.source == SRC_DYNAMIC) begin
            pred_taken = ctr[CNT_W-1];
        end else begin
            pred_taken = static_taken;
        end
    end

    // R11
    idle_no_pred_chk: assert property (@(posedge clk) disable iff (rst)
        !fetch_valid |-> !pred_taken);

    // R2
    back_taken_rule_chk: assert property (@(posedge clk) disable iff (rst)
        (fetch_valid && fetch_hint == 2'b00) |-> pred_taken == fetch_backward);

    // R3
    fwd_taken_rule_chk: assert property (@(posedge clk) disable iff (rst)
        (fetch_valid && fetch_hint == 2'b01) |-> pred_taken != fetch_backward);

    // R4
    static_no_read_chk: assert property (@(posedge clk) disable iff (rst)
        (fetch_valid && !fetch_hint[1]) |=> access_count == $past(access_count));
endmodule

// File: tb/test_hybrid_bpred.sv
`timescale 1ns/1ps
module test_hybrid_bpred;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        fetch_valid = 1'b0;
    logic [31:0] fetch_pc = '0;
    logic        fetch_backward = 1'b0;
    logic [1:0]  fetch_hint = '0;
    logic        res_valid = 1'b0;
    logic        res_taken = 1'b0;
    logic        res_dynamic = 1'b0;
    logic [3:0]  res_index = '0;
    logic        pred_taken;
    logic [3:0]  pred_index;
    logic [31:0] access_count;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    // reference model state
    int          m_tbl[16];
    int          m_hist;
    int unsigned m_acc;
    int          idx_q[$];

    always #2 clk = ~clk;

    hybrid_bpred i_hybrid_bpred (
        .clk(clk), .rst(rst),
        .fetch_valid(fetch_valid), .fetch_pc(fetch_pc),
        .fetch_backward(fetch_backward), .fetch_hint(fetch_hint),
        .res_valid(res_valid), .res_taken(res_taken),
        .res_dynamic(res_dynamic), .res_index(res_index),
        .pred_taken(pred_taken), .pred_index(pred_index),
        .access_count(access_count)
    );

    task automatic chk(bit ok, string what, longint got, longint exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s got=%0d exp=%0d", what, got, exp);
        end
    endtask

    task automatic model_reset();
        foreach (m_tbl[e]) m_tbl[e] = 1;
        m_hist = 0;
        m_acc  = 0;
        idx_q.delete();
    endtask

    // one cycle: drive at falling edge, compare, advance model to next edge
    task automatic step(bit fv, bit [31:0] pc, bit bw, bit [1:0] hint,
                        bit rv, bit rt, bit rd, bit [3:0] ridx, string tag);
        int  e_idx;
        bit  e_pred;
        string ptag;
        @(negedge clk);
        fetch_valid = fv; fetch_pc = pc; fetch_backward = bw; fetch_hint = hint;
        res_valid = rv; res_taken = rt; res_dynamic = rd; res_index = ridx;
        #1;
        e_idx = (int'(pc[5:2]) ^ m_hist) & 15;
        if (!fv) begin
            e_pred = 1'b0; ptag = "R11";
        end else if (hint[1]) begin
            e_pred = (m_tbl[e_idx] >= 2); ptag = "R7";
        end else if (hint[0]) begin
            e_pred = !bw; ptag = "R3";
        end else begin
            e_pred = bw; ptag = "R2";
        end
        chk(pred_taken === e_pred, {ptag, " ", tag, " pred_taken"}, pred_taken, e_pred);
        chk(pred_index === 4'(e_idx), {"R6 ", tag, " pred_index"}, pred_index, e_idx);
        chk(access_count === m_acc, {"R10 ", tag, " access_count"}, access_count, m_acc);
        // model update at the coming edge (R12: prediction above used old state)
        if (fv && hint[1]) begin
            m_acc++;
            idx_q.push_back(e_idx);
        end
        if (rv) begin
            if (rd) begin   // R8; static resolves leave table alone (R5)
                if (rt && m_tbl[ridx] < 3) m_tbl[ridx]++;
                if (!rt && m_tbl[ridx] > 0) m_tbl[ridx]--;
            end
            m_hist = ((m_hist << 1) | int'(rt)) & 15;   // R9
        end
        @(posedge clk);
    endtask

    function automatic bit [31:0] pc_for(int idx);
        return 32'(((idx ^ m_hist) & 15) << 2) | 32'h0000_1000;
    endfunction

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog expired");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        model_reset();
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        #1;
        // R1: counter cleared
        chk(access_count === 32'd0, "R1 access_count after reset", access_count, 0);
        // R1: weak not-taken everywhere, history zero
        for (int k = 0; k < 16; k++)
            step(1, 32'(k << 2), 0, 2'b10, 0, 0, 0, 0, "R1 reset table");

        // R2 / R3 static polarity, and R4 no table reads
        step(1, 32'h40, 1, 2'b00, 0, 0, 0, 0, "R2 backward");
        step(1, 32'h40, 0, 2'b00, 0, 0, 0, 0, "R2 forward R4");
        step(1, 32'h40, 1, 2'b01, 0, 0, 0, 0, "R3 backward");
        step(1, 32'h40, 0, 2'b01, 0, 0, 0, 0, "R3 forward R4");
        // R11 idle with dynamic hint
        step(0, 32'h44, 1, 2'b10, 0, 0, 0, 0, "R11 idle");

        // R8 saturate entry 5 upward then downward
        for (int k = 0; k < 5; k++) begin
            step(0, 0, 0, 0, 1, 1, 1, 4'd5, "R8 up");
            step(1, pc_for(5), 0, 2'b10, 0, 0, 0, 0, "R8 read up");
        end
        for (int k = 0; k < 5; k++) begin
            step(0, 0, 0, 0, 1, 0, 1, 4'd5, "R8 down");
            step(1, pc_for(5), 0, 2'b10, 0, 0, 0, 0, "R8 read down");
        end

        // R5 static resolves must not train; R9 they still shift history
        for (int k = 0; k < 6; k++)
            step(0, 0, 0, 0, 1, 1, 0, 4'd9, "R5 R9 static resolve");
        for (int k = 0; k < 16; k++)
            step(1, 32'(k << 2), 0, 2'b10, 0, 0, 0, 0, "R5 R9 table sweep");

        // R12 fetch and resolve to the same entry in one cycle
        step(0, 0, 0, 0, 1, 1, 1, 4'd3, "R12 prime");
        step(1, pc_for(3), 0, 2'b10, 1, 1, 1, 4'd3, "R12 same cycle");
        step(1, pc_for(3), 0, 2'b10, 0, 0, 0, 0, "R12 after");

        // random mixed traffic
        for (int n = 0; n < 4000; n++) begin
            bit        fv = ($urandom % 4) != 0;
            bit [1:0]  h  = 2'($urandom);
            bit        rv = ($urandom % 2) != 0;
            bit        rd = ($urandom % 2) != 0;
            bit [3:0]  ri;
            if (rv && rd && idx_q.size() > 0) ri = 4'(idx_q.pop_front());
            else ri = 4'($urandom);
            if (idx_q.size() > 32) void'(idx_q.pop_front());
            step(fv, $urandom, 1'($urandom), h, rv, 1'($urandom), rd, ri, "random");
        end

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule